// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is an on-chip synchronous static RAM with a late-write interface. A read and a write can follow each other on every clock with no idle cycle in between. Each access is a command sampled on the rising clock edge. A write command carries its address and byte enables, and its data follows on the bus some cycles later. The same bus cycles that a read uses for its output data are therefore free to carry write data.

The `pipe_mode` strap is static and selects the read latency.

- **Pipelined reads** go through an output register, and write data trails its address by two edges.
- **Flow-through reads** appear right after the sampling edge, and write data trails its address by one edge.

Pending writes sit in two command holding stages. A read that hits a write whose data arrives on the same edge takes the new bytes directly from the bus.

Bursts of up to four beats step the low two address bits, in linear or interleaved order. The order is chosen by the static `ilv_order` strap. Output enable and sleep act without the clock.

Top module: `zt_sram`

## Requirements
- R1: A command is taken on a rising edge only when `sel_a`, `sel_b` and `sel_c` are all 1 and `adv` is 0. Otherwise, with `adv` 0, the cycle is a deselect and yields no output.
- R2: With `pipe_mode`=1, data for a read sampled on edge k is driven after edge k+1.
- R3: With `pipe_mode`=0, data for a read sampled on edge k is driven after edge k itself.
- R4: Write data is taken from `wdata` on the second edge after its command (`pipe_mode`=1) or on the first (`pipe_mode`=0). A write command never drives the output.
- R5: Reads and writes may alternate on consecutive edges. A read returns the result of every earlier write command, including writes whose data is still in flight. Pending bytes are forwarded from the bus.
- R6: Bytes are 9 bits wide. Byte enable bit i writes bits 9i+8..9i of the word, and bytes whose enable is 0 keep their old contents.
- R7: With `ilv_order`=0, beat n of a burst uses low address bits equal to (start + n) mod 4. The upper bits stay fixed (for example, start 1 gives 1,2,3,0).
- R8: With `ilv_order`=1, beat n uses low bits equal to start XOR n (for example, start 1 gives 1,0,3,2).
- R9: `adv`=1 continues the open burst with the read or write type of the command that opened it. `adv`=1 with no open burst is a deselect.
- R10: While `oe` is 0, `rdrive` is 0 and `rdata` is all zeros, regardless of the clock.
- R11: While `sleep` is 1, `rdrive` is 0. Commands sampled during sleep are ignored, and any open burst is closed.
- R12: During and right after reset, nothing is driven and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | Static strap: 1 for pipelined reads, 0 for flow-through reads |
| ilv_order | input | 1 | Static strap: 1 for interleaved burst order, 0 for linear |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| adv | input | 1 | Continue the open burst |
| wr | input | 1 | 1 for a write command, 0 for a read |
| byte_en | input | NB | Byte write enables, sampled with the command |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Late write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down |
| rdata | output | NB*BW | Read data, zero when not driven |
| rdrive | output | 1 | Output drivers active |

## Verification
The bench builds the block with AW=6, NB=2 and BW=9: a 64-word array of two 9-bit bytes. Random addresses are confined to the lowest 16 words. This makes reads land on in-flight writes often, so forwarding with partial byte enables is exercised in both latency modes. Four-beat bursts wrap inside aligned groups, so both address orders become visible. All four combinations of the two straps are run.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             ilv_order,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c,
  input  logic             adv,
  input  logic             wr,
  input  logic [NB-1:0]    byte_en,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wdata,
  input  logic             oe,
  input  logic             sleep,
  output logic [NB*BW-1:0] rdata,
  output logic             rdrive
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          b_act, b_we;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic          c1_v, c1_we, c2_v, c2_we;
  logic [AW-1:0] c1_a, c2_a;
  logic [NB-1:0] c1_be, c2_be;

  logic          out_v;
  logic [DW-1:0] out_q;

  wire       start = !sleep && !adv && sel_a && sel_b && sel_c;
  wire       cont  = !sleep && adv && b_act;
  wire [1:0] nc    = b_cnt + 2'd1;
  wire [1:0] off   = ilv_order ? (b_base[1:0] ^ nc) : (b_base[1:0] + nc);

  wire [AW-1:0] acc_a  = start ? addr : {b_base[AW-1:2], off};
  wire          acc_we = start ? wr : b_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_we   <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
    end else if (start) begin
      b_act  <= 1'b1;
      b_we   <= wr;
      b_base <= addr;
      b_cnt  <= '0;
    end else if (cont) begin
      b_cnt  <= nc;
    end else begin
      b_act  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_v  <= 1'b0;
      c1_we <= 1'b0;
      c1_a  <= '0;
      c1_be <= '0;
      c2_v  <= 1'b0;
      c2_we <= 1'b0;
      c2_a  <= '0;
      c2_be <= '0;
    end else begin
      c1_v  <= start || cont;
      c1_we <= acc_we;
      c1_a  <= acc_a;
      c1_be <= byte_en;
      c2_v  <= c1_v;
      c2_we <= c1_we;
      c2_a  <= c1_a;
      c2_be <= c1_be;
    end
  end

  wire          wc_v  = pipe_mode ? (c2_v && c2_we) : (c1_v && c1_we);
  wire [AW-1:0] wc_a  = pipe_mode ? c2_a : c1_a;
  wire [NB-1:0] wc_be = pipe_mode ? c2_be : c1_be;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (wc_v && wc_be[i])
        mem[wc_a][i*BW +: BW] <= wdata[i*BW +: BW];
  end

  wire [DW-1:0] rd_raw = mem[c1_a];
  wire          hit    = c2_v && c2_we && (c2_a == c1_a);
  logic [DW-1:0] fwd;

  for (genvar i = 0; i < NB; i++) begin : g_fwd
    assign fwd[i*BW +: BW] = (hit && c2_be[i]) ? wdata[i*BW +: BW] : rd_raw[i*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_q <= '0;
    end else begin
      out_v <= c1_v && !c1_we;
      out_q <= fwd;
    end
  end

  wire          dv   = pipe_mode ? out_v : (c1_v && !c1_we);
  wire [DW-1:0] dsel = pipe_mode ? out_q : rd_raw;

  assign rdrive = dv && oe && !sleep;
  assign rdata  = rdrive ? dsel : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pipe_mode,
  input logic          sel_a,
  input logic          sel_b,
  input logic          sel_c,
  input logic          adv,
  input logic          wr,
  input logic          oe,
  input logic          sleep,
  input logic [DW-1:0] rdata,
  input logic          rdrive
);
  wire sel_all = sel_a && sel_b && sel_c;
  wire iss_rd  = !sleep && !adv && sel_all && !wr;
  wire iss_wr  = !sleep && !adv && sel_all && wr;

  AST_PIPE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode && oe && !sleep && $past(rst_n) && $past(rst_n, 2) && $past(iss_rd, 2) |-> rdrive); // R2
  AST_FLOW_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode && oe && !sleep && $past(rst_n) && $past(iss_rd) |-> rdrive); // R3
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode && $past(rst_n) && $past(iss_wr) |-> !rdrive); // R4
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode && $past(rst_n) && $past(!adv && !sel_all) |-> !rdrive); // R1
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!rdrive && rdata == '0)); // R10
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdrive); // R11
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !rdrive); // R12
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
  .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
  .adv(adv), .wr(wr), .oe(oe), .sleep(sleep),
  .rdata(rdata), .rdrive(rdrive)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int CLK_P = 10;
  localparam int AW = 6, NB = 2, BW = 9, DW = NB * BW, DEPTH = 1 << AW;
  localparam int N = 300;

  logic clk = 0, rst_n = 0, pipe_mode = 0, ilv_order = 0;
  logic sel_a = 0, sel_b = 0, sel_c = 0, adv = 0, wr = 0, oe = 1, sleep = 0;
  logic [NB-1:0] byte_en = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdrive;

  zt_sram #(.AW(AW), .NB(NB), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ilv_order(ilv_order),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .adv(adv), .wr(wr),
    .byte_en(byte_en), .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rdrive(rdrive)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [2:0]    s_sel [N];
  bit            s_adv [N], s_wr [N], s_oe [N], s_sl [N];
  logic [NB-1:0] s_be  [N];
  logic [AW-1:0] s_a   [N];
  logic [DW-1:0] s_wd  [N];
  bit            e_drv [N];
  logic [DW-1:0] e_dat [N];
  string         e_tag [N];
  logic [DW-1:0] mdl   [DEPTH];
  int            lw    [DEPTH];
  logic [NB-1:0] lbe   [DEPTH];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [1:0] boff(logic [1:0] s, logic [1:0] k, bit il);
    return il ? (s ^ k) : (s + k);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int t = 0; t < N; t++) begin
      s_sel[t] = 3'b000; s_adv[t] = 0; s_wr[t] = 0; s_oe[t] = 1; s_sl[t] = 0;
      s_be[t] = '1; s_a[t] = '0; s_wd[t] = DW'($urandom);
    end
  endtask

  task automatic put(int t, logic [2:0] sl, bit av, bit w, int a, logic [NB-1:0] be);
    s_sel[t] = sl; s_adv[t] = av; s_wr[t] = w; s_a[t] = AW'(a); s_be[t] = be;
  endtask

  task automatic build_exp(bit p, bit il);
    bit act, bwe, cmd, cw, beat;
    logic [AW-1:0] base, ca;
    logic [1:0] cnt;
    int L, P, o;
    act = 0; bwe = 0; base = '0; cnt = '0;
    L = p ? 2 : 1;
    P = p ? 1 : 0;
    for (int t = 0; t < N; t++) begin
      e_drv[t] = 0; e_dat[t] = '0; e_tag[t] = "R12";
    end
    for (int t = 0; t < N; t++) begin
      cmd = 0; cw = 0; beat = 0; ca = '0;
      if (s_sl[t]) act = 0;
      else if (!s_adv[t]) begin
        if (s_sel[t] == 3'b111) begin
          act = 1; base = s_a[t]; cnt = 0; bwe = s_wr[t];
          cmd = 1; cw = s_wr[t]; ca = s_a[t];
        end else act = 0;
      end else if (act) begin
        cnt = cnt + 2'd1;
        cmd = 1; cw = bwe; beat = 1;
        ca = {base[AW-1:2], boff(base[1:0], cnt, il)};
      end
      o = t + P;
      if (o < N) begin
        if (!cmd) e_tag[o] = (s_adv[t] && !s_sl[t]) ? "R9" : "R1";
        else if (cw) e_tag[o] = "R4";
        else if (beat) e_tag[o] = il ? "R8" : "R7";
        else if (t - lw[ca] <= 2) e_tag[o] = "R5";
        else if (lbe[ca] != '1) e_tag[o] = "R6";
        else e_tag[o] = p ? "R2" : "R3";
        if (cmd && !cw) begin
          e_drv[o] = s_oe[o] && !s_sl[o];
          if (e_drv[o]) e_dat[o] = mdl[ca];
        end
        if (!s_oe[o]) e_tag[o] = "R10";
        if (s_sl[o]) e_tag[o] = "R11";
      end
      if (cmd && cw) begin
        for (int i = 0; i < NB; i++)
          if (s_be[t][i]) mdl[ca][i*BW +: BW] = s_wd[t+L][i*BW +: BW];
        lw[ca] = t; lbe[ca] = s_be[t];
      end
    end
  endtask

  task automatic run_phase(bit p, bit il);
    @(negedge clk);
    rst_n = 0; pipe_mode = p; ilv_order = il;
    sel_a = 0; sel_b = 0; sel_c = 0; adv = 1; oe = 1; sleep = 0;
    repeat (2) @(negedge clk);
    chk(rdrive == 0 && rdata == '0, "R12", "reset quiet", {rdrive, rdata[DW-2:0]}, '0);
    build_exp(p, il);
    rst_n = 1;
    for (int cyc = 0; cyc < N; cyc++) begin
      {sel_a, sel_b, sel_c} = s_sel[cyc];
      adv = s_adv[cyc]; wr = s_wr[cyc]; byte_en = s_be[cyc]; addr = s_a[cyc];
      wdata = s_wd[cyc]; oe = s_oe[cyc]; sleep = s_sl[cyc];
      @(negedge clk);
      chk(rdrive == e_drv[cyc], e_tag[cyc], "rdrive", DW'(rdrive), DW'(e_drv[cyc]));
      chk(rdata == e_dat[cyc], e_tag[cyc], "rdata", rdata, e_dat[cyc]);
    end
  endtask

  task automatic make_mixed();
    clear_stim();
    put(0, 3'b111, 1, 0, 0, 2'b11);   // R9: advance with no open burst
    put(1, 3'b111, 0, 1, 5, 2'b11);
    put(2, 3'b111, 0, 1, 5, 2'b01);   // R6: low byte only
    put(3, 3'b111, 0, 0, 5, 2'b11);   // R5: read hits pending write
    put(4, 3'b111, 0, 0, 5, 2'b11);
    put(5, 3'b111, 0, 1, 6, 2'b10);
    put(6, 3'b111, 0, 0, 6, 2'b11);   // R5: read-write-read, no idle
    put(7, 3'b111, 0, 1, 6, 2'b11);
    put(8, 3'b111, 0, 0, 6, 2'b11);
    put(9, 3'b111, 0, 1, 6, 2'b11);   // R7/R8 burst write from offset 2
    for (int t = 10; t < 13; t++) put(t, 3'b000, 1, 0, 0, 2'b11);
    put(13, 3'b111, 0, 0, 5, 2'b11);  // burst read from offset 1, wraps
    for (int t = 14; t < 18; t++) put(t, 3'b011, 1, 0, 0, 2'b11);
    put(18, 3'b111, 0, 0, 4, 2'b11); s_oe[18] = 0; s_oe[19] = 0; // R10
    put(19, 3'b110, 0, 0, 4, 2'b11);  // R1: one select low
    for (int t = 20; t < N - 4; t++) begin
      s_sel[t] = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'b111;
      s_adv[t] = ($urandom % 3 == 0);
      s_wr[t]  = $urandom % 2;
      s_a[t]   = AW'($urandom % 16);
      s_be[t]  = NB'($urandom);
      s_oe[t]  = ($urandom % 10) != 0;
      s_sl[t]  = ($urandom % 25) == 0;   // R11
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < DEPTH; a++) begin mdl[a] = '0; lw[a] = -100; lbe[a] = '1; end
    clear_stim();
    for (int a = 0; a < DEPTH; a++) put(a, 3'b111, 0, 1, a, 2'b11);
    run_phase(0, 0);
    for (int a = 0; a < DEPTH; a++) lw[a] = -100;
    for (int ph = 0; ph < 4; ph++) begin
      make_mixed();
      run_phase(ph < 2, ph[0]);
      for (int a = 0; a < DEPTH; a++) lw[a] = -100;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule